// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer Counter

This block is an 8-bit up-counter that advances on ticks from a hidden 7-bit binary prescaler. The prescaler counts ticks from one of two sources: the system clock itself, or rising edges of an external frequency input after synchronization into the system clock domain. A 3-bit tap field sets the division to 2^n, for n from 0 to 7. When the counter passes FFh, it reloads from a reload register and raises an overflow pulse for one cycle.

Software drives three write strobes, one each for a control word, the reload value and the live count. The count value is always visible on an output. Writing the count loads it directly and clears the prescaler. A self-clearing force bit in the control word does the same with the reload value. Clearing the enable bit freezes both the counter and the prescaler, so counting resumes at the same prescaler phase.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset, `count_o` is 00h, `ovf_o` is 0, `reload_o` is 00h and `ctrl_o` is all zero. This means disabled, system clock source, tap 0 and no force pending.
- R2: The control word fields are: bit 0 enable, bits 3:1 tap select n, bit 4 source select (1 = external input), bit 5 force reload.
- R3: While enabled, the counter advances once every 2^n source ticks. If the prescaler is cleared at a clock edge, the count k edges later (system clock source) is the loaded value plus floor(k / 2^n).
- R4: On the tick that finds the count at FFh, the count becomes the reload value. `ovf_o` is high for exactly the one cycle in which that reload value is first shown.
- R5: While enable is clear, the count and the prescaler hold. After enable is set again, counting continues from the prescaler phase that was frozen.
- R6: A count write loads `count_wdata_i` at the next edge, whether enable is set or clear, and clears the prescaler. `count_o` always shows the live count.
- R7: If the force bit and the enable bit are both set, the next edge loads the reload value, clears the prescaler and clears the force bit. If enable is clear, the force bit stays set and has no effect.
- R8: With the external source selected, each rising edge of `ext_freq_i` is synchronized through two flops and gives exactly one source tick. A level held high gives no further ticks.
- R9: A count write in the same cycle as an overflow tick takes priority. The written value is loaded and no overflow pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_freq_i | input | 1 | External frequency input, asynchronous |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 6 | Control word write data |
| reload_wr_i | input | 1 | Reload register write strobe |
| reload_wdata_i | input | 8 | Reload value write data |
| count_wr_i | input | 1 | Count write strobe |
| count_wdata_i | input | 8 | Count write data |
| ctrl_o | output | 6 | Current control word, including the pending force bit |
| reload_o | output | 8 | Current reload value |
| count_o | output | 8 | Live count |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
A software write to the count and an overflow tick from the prescaler can land on the same clock edge. The bench provokes this by loading FEh at tap 0 and then issuing a second count write in the cycle where the count sits at FFh. It judges the result from the ports: the count must show the written value, `ovf_o` must stay low and the next tick must advance from the written value. A similar overlap is checked for the force-reload path against a running prescaler. In that case the count must show the reload value, the prescaler must restart from zero and the force bit must drop after one cycle.

// File: rtl/timer_pkg.sv
// Package: shared widths and the control word layout for the reload timer.
// Assumes: tap select width is wide enough to name every prescaler bit.
package timer_pkg;
    localparam int CNT_W  = 8;
    localparam int PSC_W  = 7;
    localparam int TAP_W  = $clog2(PSC_W + 1);
    localparam int CTRL_W = TAP_W + 3;

    typedef struct packed {
        logic             force_rl;  // bit 5: force reload, self-clearing
        logic             src_ext;   // bit 4: 1 = external frequency input
        logic [TAP_W-1:0] tap;       // bits 3:1: prescaler tap n
        logic             enable;    // bit 0: counter and prescaler run
    } ctrl_t;
endpackage

// File: rtl/timer_tick_source.sv
// Module: picks the source tick for the prescaler.
// With the system clock selected, every cycle is a tick. With the external
// input selected, the input goes through a synchronizer chain and each
// rising edge becomes one tick of one cycle.
// Assumes: the external input is asynchronous and slower than clk / 2.
module timer_tick_source #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    input  logic sel_ext_i,
    output logic tick_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   ext_edge;

    // Synchronizer chain plus delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
            prev_q <= sync_q[MSB];
        end
    end

    // Rising edge of the synchronized input.
    always_comb ext_edge = sync_q[MSB] & ~prev_q;

    // Source tick: every cycle, or one cycle per external rising edge.
    always_comb tick_o = sel_ext_i ? ext_edge : 1'b1;

    // R8: an external edge never yields two ticks in a row.
    a_r8_single_edge_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ext_edge |=> !ext_edge);
endmodule

// File: rtl/timer_prescaler.sv
// Module: hidden binary prescaler with a tap select.
// It counts source ticks while enabled. It emits a counter tick when the low
// n bits are all ones on a source tick, which divides by 2^n.
// Assumes: clear has priority. Software cannot read or write the prescaler.
module timer_prescaler #(
    parameter int PSC_W = 7,
    parameter int TAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             src_tick_i,
    input  logic             clr_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] tap_mask;

    // Mask of the low n bits selected by the tap field.
    always_comb tap_mask = (PSC_W'(1) << tap_i) - PSC_W'(1);

    // Counter tick when every selected low bit is one.
    always_comb tick_o = en_i & src_tick_i & ((psc_q & tap_mask) == tap_mask);

    // Prescaler register: clear, advance on a source tick, or freeze.
    always_ff @(posedge clk) begin
        if (!rst_n)                  psc_q <= '0;
        else if (clr_i)              psc_q <= '0;
        else if (en_i && src_tick_i) psc_q <= psc_q + PSC_W'(1);
    end

    // R6 R7: a clear request leaves the prescaler at zero.
    a_r6_psc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (psc_q == '0));
    // R5: a disabled prescaler holds its value.
    a_r5_psc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(psc_q));
endmodule

// File: rtl/timer_regs.sv
// Module: control word and reload register.
// The force bit clears itself on the edge where it acts, which needs the
// enable bit to be set. A control write in the same cycle takes priority.
// Assumes: write strobes are one cycle wide, in the clk domain.
module timer_regs
    import timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr_i,
    input  ctrl_t            ctrl_wdata_i,
    input  logic             reload_wr_i,
    input  logic [CNT_W-1:0] reload_wdata_i,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             force_go_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;

    // The force request acts only when enable is also set.
    always_comb force_go_o = ctrl_q.force_rl & ctrl_q.enable;

    // Control word: software write, otherwise self-clear of the force bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          ctrl_q <= '0;
        else if (ctrl_wr_i)  ctrl_q <= ctrl_wdata_i;
        else if (force_go_o) ctrl_q.force_rl <= 1'b0;
    end

    // Reload register: loaded only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)           reload_q <= '0;
        else if (reload_wr_i) reload_q <= reload_wdata_i;
    end

    always_comb ctrl_o   = ctrl_q;
    always_comb reload_o = reload_q;

    // R7: a force request that has acted is gone one cycle later.
    a_r7_force_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (force_go_o && !ctrl_wr_i) |=> !ctrl_q.force_rl);
    // R7: without enable, a pending force request stays.
    a_r7_force_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.force_rl && !ctrl_q.enable && !ctrl_wr_i) |=> ctrl_q.force_rl);
endmodule

// File: rtl/timer_counter.sv
// Module: auto-reload up-counter.
// Priority: software load, then force reload, then tick. A tick at
// all-ones reloads and raises a one-cycle overflow flag.
// Assumes: the tick is already gated by enable and the prescaler.
module timer_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             force_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    // Count register and overflow flag, updated together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (load_i) begin
                cnt_q <= load_val_i;
            end else if (force_i) begin
                cnt_q <= reload_i;
            end else if (tick_i) begin
                if (cnt_q == CNT_MAX) begin
                    cnt_q <= reload_i;
                    ovf_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    always_comb cnt_o = cnt_q;
    always_comb ovf_o = ovf_q;

    // R4: an overflow pulse follows all-ones and shows the reload value.
    a_r4_ovf_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> ($past(cnt_q) == CNT_MAX && cnt_q == $past(reload_i)));
    // R4: the pulse lasts one cycle when no further overflow can follow.
    a_r4_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && cnt_q != CNT_MAX) |=> !ovf_q);
    // R6 R9: a software load always wins and never signals overflow.
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i) && !ovf_q));
    // R5: with no tick, load or force, the count holds.
    a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !force_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/prescaled_reload_timer.sv
// Module: top of the prescaled auto-reload timer.
// Connects the tick source, the hidden prescaler, the register block and
// the counter. Both the count write and the force reload clear the prescaler.
// Assumes: all strobes are synchronous to clk. ext_freq_i is asynchronous.
module prescaled_reload_timer
    import timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_freq_i,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              reload_wr_i,
    input  logic [CNT_W-1:0]  reload_wdata_i,
    input  logic              count_wr_i,
    input  logic [CNT_W-1:0]  count_wdata_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o
);
    ctrl_t ctrl;
    logic  force_go;
    logic  src_tick;
    logic  cnt_tick;
    logic  psc_clr;

    // Either initialization path restarts the prescaler.
    always_comb psc_clr = count_wr_i | force_go;

    timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctrl_wr_i      (ctrl_wr_i),
        .ctrl_wdata_i   (ctrl_t'(ctrl_wdata_i)),
        .reload_wr_i    (reload_wr_i),
        .reload_wdata_i (reload_wdata_i),
        .ctrl_o         (ctrl),
        .reload_o       (reload_o),
        .force_go_o     (force_go)
    );

    timer_tick_source #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_i     (ext_freq_i),
        .sel_ext_i (ctrl.src_ext),
        .tick_o    (src_tick)
    );

    timer_prescaler #(.PSC_W(PSC_W), .TAP_W(TAP_W)) u_psc (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctrl.enable),
        .src_tick_i (src_tick),
        .clr_i      (psc_clr),
        .tap_i      (ctrl.tap),
        .tick_o     (cnt_tick)
    );

    timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (count_wr_i),
        .load_val_i (count_wdata_i),
        .force_i    (force_go),
        .reload_i   (reload_o),
        .tick_i     (cnt_tick),
        .cnt_o      (count_o),
        .ovf_o      (ovf_o)
    );

    always_comb ctrl_o = ctrl;

    // R5: with enable clear, the count changes only through a software write.
    a_r5_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.enable && !count_wr_i) |=> $stable(count_o));
endmodule

// File: tb/prescaled_reload_timer_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module prescaled_reload_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_freq_i = 1'b0;
    logic       ctrl_wr_i = 1'b0;
    logic [5:0] ctrl_wdata_i = '0;
    logic       reload_wr_i = 1'b0;
    logic [7:0] reload_wdata_i = '0;
    logic       count_wr_i = 1'b0;
    logic [7:0] count_wdata_i = '0;
    logic [5:0] ctrl_o;
    logic [7:0] reload_o;
    logic [7:0] count_o;
    logic       ovf_o;

    int checks = 0;
    int errors = 0;

    // Control word bits (R2).
    localparam logic [5:0] EN    = 6'b000001;
    localparam logic [5:0] EXT   = 6'b010000;
    localparam logic [5:0] FORCE = 6'b100000;

    always #2 clk = ~clk;

    prescaled_reload_timer u_prescaled_reload_timer (.*);

    function automatic logic [5:0] tap(input int n);
        return 6'(n << 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [5:0] d);
        ctrl_wr_i = 1'b1; ctrl_wdata_i = d;
        @(negedge clk);
        ctrl_wr_i = 1'b0;
    endtask

    task automatic write_reload(input logic [7:0] d);
        reload_wr_i = 1'b1; reload_wdata_i = d;
        @(negedge clk);
        reload_wr_i = 1'b0;
    endtask

    task automatic write_count(input logic [7:0] d);
        count_wr_i = 1'b1; count_wdata_i = d;
        @(negedge clk);
        count_wr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 count", count_o, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 ctrl", ctrl_o, 0);
        chk("R1 reload", reload_o, 0);
    endtask

    task automatic t_division(input int n);
        write_ctrl(EN | tap(n));
        write_count(8'h10);
        step((1 << n) - 1);
        chk("R3 before tick", count_o, 8'h10);
        step(1);
        chk("R3 first tick", count_o, 8'h11);
        step(2 * (1 << n));
        chk("R3 third tick", count_o, 8'h13);
    endtask

    task automatic t_overflow();
        write_ctrl(EN | tap(0));
        write_reload(8'h40);
        write_count(8'hFE);
        step(1);
        chk("R4 at FF", count_o, 8'hFF);
        chk("R4 no ovf yet", ovf_o, 0);
        step(1);
        chk("R4 reloaded", count_o, 8'h40);
        chk("R4 ovf pulse", ovf_o, 1);
        step(1);
        chk("R4 after", count_o, 8'h41);
        chk("R4 ovf dropped", ovf_o, 0);
    endtask

    task automatic t_freeze();
        write_ctrl(EN | tap(2));
        write_count(8'h50);
        write_ctrl(tap(2));           // prescaler advances once more here
        step(10);
        chk("R5 frozen count", count_o, 8'h50);
        write_count(8'h60);           // R6: write works while disabled
        chk("R6 write disabled", count_o, 8'h60);
        write_ctrl(EN | tap(2));
        step(3);
        chk("R5 resumed phase", count_o, 8'h60);
        step(1);
        chk("R5 first tick", count_o, 8'h61);
    endtask

    task automatic t_freeze_phase();
        write_ctrl(EN | tap(2));
        write_count(8'h50);
        write_ctrl(tap(2));           // prescaler now 1, frozen
        step(10);
        write_ctrl(EN | tap(2));
        step(2);
        chk("R5 held phase", count_o, 8'h50);
        step(1);
        chk("R5 held phase tick", count_o, 8'h51);
    endtask

    task automatic t_force();
        write_ctrl(EN | tap(1));
        write_reload(8'h80);
        write_ctrl(EN | tap(1) | FORCE);
        chk("R7 force visible", ctrl_o[5], 1);
        step(1);
        chk("R7 loaded", count_o, 8'h80);
        chk("R7 self clear", ctrl_o[5], 0);
        step(1);
        chk("R7 prescaler cleared", count_o, 8'h80);
        step(1);
        chk("R7 prescaler cleared tick", count_o, 8'h81);
        write_ctrl(FORCE | tap(1));   // pending, no enable
        step(6);
        chk("R7 pending no load", count_o, 8'h81);
        chk("R7 pending bit", ctrl_o[5], 1);
        write_ctrl(6'b0);
    endtask

    task automatic t_collision();
        write_ctrl(EN | tap(0));
        write_reload(8'h33);
        write_count(8'hFE);
        step(1);
        chk("R9 at FF", count_o, 8'hFF);
        write_count(8'h20);
        chk("R9 write wins", count_o, 8'h20);
        chk("R9 no ovf", ovf_o, 0);
        step(1);
        chk("R9 continues", count_o, 8'h21);
    endtask

    task automatic t_external();
        write_ctrl(EN | EXT | tap(0));
        write_count(8'h00);
        for (int i = 0; i < 5; i++) begin
            ext_freq_i = 1'b1; step(4);
            ext_freq_i = 1'b0; step(4);
        end
        step(4);
        chk("R8 five edges", count_o, 5);
        ext_freq_i = 1'b1;
        step(20);
        chk("R8 held level", count_o, 6);
        ext_freq_i = 1'b0;
        step(4);
        chk("R8 falling edge", count_o, 6);
    endtask

    initial begin
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_division(0);
        t_division(3);
        t_division(7);
        t_overflow();
        t_freeze();
        t_freeze_phase();
        t_force();
        t_collision();
        t_external();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule